// File: doc/BRIEF.md
# Double-Buffered DAC Update Sequencer

This block is the digital control core of a 12-bit voltage DAC. Software loads a value into a next-value register. The block copies that value into the current-value register on a DAC clock tick. An external strobe can throttle these copies, either as a one-shot edge trigger or as a level that must be held high. The current value is decoded into the code sent to the converter. The decoding either passes the value through or flips its top bit, so that a signed value is shown as an offset-binary code. After every change of the current value, a deglitch window opens the output-side switches for a programmable number of cycles. Each copy also raises an empty-buffer interrupt, which software can set, clear and mask.

The block is driven through a simple synchronous register port with a write strobe and a combinational read port. Its register map uses a 4-bit word address and 16-bit data:

| Address | Register |
| --- | --- |
| 0x0 | configuration |
| 0x1 | current value |
| 0x2 | next value |
| 0x3 | interrupt flag, write 1 to clear |
| 0x4 | interrupt set, write 1 to set, reads 0 |
| 0x5 | interrupt mask |
| 0x6 | masked interrupt, read-only |
| 0x7 | switch set, write 1 to set, reads the switch state |
| 0x8 | switch clear, write 1 to clear, reads the switch state |

In both switch registers, bit 0 is the supply switch and bit 1 is the pin switch.

Top module: `dac_update_seq`

## Requirements
- R1: A performed update copies the next value (address 0x2, bits 11:0) into the current value (address 0x1) on the clock edge of the tick. The next value is left unchanged, and the interrupt flag (address 0x3, bit 0) becomes 1.
- R2: With strobe gating off (configuration bit 13 = 0), every tick performs an update and the strobe input has no effect. No update happens in a cycle without a tick.
- R3: With strobe gating on and edge mode selected (bit 13 = 1, bit 14 = 0), a rising edge of the strobe arms one update. The first tick on a clock edge after the edge performs that update. A tick on the same clock edge as the strobe edge does not use it. Further edges while an update is armed are ignored. The armed state is cleared when the update is performed.
- R4: With strobe gating on and level mode selected (bit 13 = 1, bit 14 = 1), a tick performs an update only while the strobe is high.
- R5: The code mode (configuration bits 11:10) sets the output code. Mode 1 gives the current value with bit 11 inverted. Modes 0, 2 and 3 give the current value unchanged.
- R6: After each update and after each software write to the current value, a deglitch window stays active for L+1 clock cycles. L is the deglitch length in configuration bits 5:0.
- R7: During the window, the pin switch is open if configuration bit 6 is 1, and the buffer switch is open if configuration bit 7 is 1. Outside the window, the pin switch follows switch bit 1, the supply switch follows switch bit 0, and the buffer switch is closed.
- R8: The interrupt flag is set by writing 1 to bit 0 of address 0x4 and cleared by writing 1 to bit 0 of address 0x3. Writing 0 to either leaves it unchanged. irqOut and address 0x6 show the flag ANDed with the mask (address 0x5, bit 0).
- R9: With the core enable (configuration bit 15) at 0, every switch output is open, no update is performed, and the output select is hi-Z (0).
- R10: With the core enable at 1, the output select is as follows. If output-on (bit 8) is 1, it is drive (1). Otherwise, if off-drive (bit 12) is 1, it is low (2) when range-up (bit 9) is 0 and reference (3) when range-up is 1. Otherwise it is hi-Z (0). rangeLift equals range-up.
- R11: When an update and a write-1-to-clear of the interrupt flag happen in the same cycle, the flag ends up at 1.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 4 | Register write address |
| wrData | input | 16 | Register write data |
| rdAddr | input | 4 | Register read address |
| rdData | output | 16 | Register read data (combinational) |
| strobeIn | input | 1 | External update throttle strobe |
| dacTick | input | 1 | DAC clock-enable tick, one cycle wide |
| dacCode | output | 12 | Decoded code for the converter |
| outSel | output | 2 | Output level select: 0 hi-Z, 1 drive, 2 low, 3 reference |
| rangeLift | output | 1 | Bottom-switch close request that lifts the output by one LSB |
| pinSwClosed | output | 1 | Output-to-pin switch closed |
| bufSwClosed | output | 1 | Output-to-buffer switch closed |
| supplySwClosed | output | 1 | Supply-to-reference-driver switch closed |
| irqOut | output | 1 | Masked empty-buffer interrupt |

## Verification
The hardest case to reach is the edge-mode one-shot. It must be shown that a tick on the same clock edge as the strobe edge is skipped, that a second edge while an update is armed does not queue a second update, and that a held-high strobe does not re-arm. The stimulus drives the strobe and the tick together cycle by cycle. It reloads the next value between ticks, so that an unwanted extra copy shows up in the current value. The deglitch window is measured for every length from 0 to 63 by counting the cycles in which the switches are open. The decoder is checked over all 4096 values in all four modes.

// File: rtl/dac_seq_pkg.sv
package dac_seq_pkg;
  parameter int VAL_W    = 12;
  parameter int GLITCH_W = 6;
  parameter int ADDR_W   = 4;
  parameter int DATA_W   = 16;

  localparam logic [ADDR_W-1:0] A_CFG    = 4'h0;
  localparam logic [ADDR_W-1:0] A_CUR    = 4'h1;
  localparam logic [ADDR_W-1:0] A_NEXT   = 4'h2;
  localparam logic [ADDR_W-1:0] A_IRQ    = 4'h3;
  localparam logic [ADDR_W-1:0] A_IRQSET = 4'h4;
  localparam logic [ADDR_W-1:0] A_MASK   = 4'h5;
  localparam logic [ADDR_W-1:0] A_MASKED = 4'h6;
  localparam logic [ADDR_W-1:0] A_SWSET  = 4'h7;
  localparam logic [ADDR_W-1:0] A_SWCLR  = 4'h8;

  // Configuration word, most significant field first
  typedef struct packed {
    logic                coreOn;       // 15
    logic                strobeLevel;  // 14
    logic                strobeGate;   // 13
    logic                offDrive;     // 12
    logic [1:0]          codeMode;     // 11:10
    logic                rangeUp;      // 9
    logic                outOn;        // 8
    logic                glitchBufEn;  // 7
    logic                glitchPinEn;  // 6
    logic [GLITCH_W-1:0] glitchLen;    // 5:0
  } cfg_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic doUpdate;
    logic curWrite;
    logic glitchOpen;
  } seq_strobe_t;

  typedef enum logic [1:0] {
    OUT_HIZ   = 2'd0,
    OUT_DRIVE = 2'd1,
    OUT_LOW   = 2'd2,
    OUT_REF   = 2'd3
  } out_sel_e;
endpackage

// File: rtl/dac_seq_ctrl.sv
module dac_seq_ctrl
  import dac_seq_pkg::*;
#(
  parameter int GW = GLITCH_W,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          coreOn,
  input  logic          strobeGate,
  input  logic          strobeLevel,
  input  logic [GW-1:0] glitchLen,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic          wrBit0,
  input  logic          strobeIn,
  input  logic          dacTick,
  output seq_strobe_t   seqStrobes,
  output logic          irqFlag,
  output logic          irqMask
);
  localparam int CNT_W = GW + 1;

  logic             strobePrev;
  logic             armed;
  logic             strobeRise;
  logic             allow;
  logic             doUpdate;
  logic             curWrite;
  logic             setHit;
  logic             clrHit;
  logic [CNT_W-1:0] glitchCnt;

  assign strobeRise = strobeIn & ~strobePrev;

  always_comb begin
    if (!strobeGate)      allow = 1'b1;
    else if (strobeLevel) allow = strobeIn;
    else                  allow = armed;
  end

  assign doUpdate = coreOn & dacTick & allow;
  assign curWrite = wrEn && (wrAddr == A_CUR);
  assign setHit   = wrEn && (wrAddr == A_IRQSET) && wrBit0;
  assign clrHit   = wrEn && (wrAddr == A_IRQ) && wrBit0;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strobePrev <= 1'b0;
      armed      <= 1'b0;
    end else begin
      strobePrev <= strobeIn;
      if (doUpdate)
        armed <= 1'b0;
      else if (strobeRise && strobeGate && !strobeLevel)
        armed <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)
      glitchCnt <= '0;
    else if (doUpdate || curWrite)
      glitchCnt <= CNT_W'(glitchLen) + CNT_W'(1);
    else if (glitchCnt != '0)
      glitchCnt <= glitchCnt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      irqFlag <= 1'b0;
      irqMask <= 1'b0;
    end else begin
      irqFlag <= doUpdate | setHit | (irqFlag & ~clrHit);
      if (wrEn && (wrAddr == A_MASK))
        irqMask <= wrBit0;
    end
  end

  assign seqStrobes.doUpdate   = doUpdate;
  assign seqStrobes.curWrite   = curWrite;
  assign seqStrobes.glitchOpen = (glitchCnt != '0);
endmodule

// File: rtl/dac_seq_datapath.sv
module dac_seq_datapath
  import dac_seq_pkg::*;
#(
  parameter int VW = VAL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  input  seq_strobe_t   seqStrobes,
  input  logic          irqFlag,
  input  logic          irqMask,
  output cfg_t          cfg,
  output logic [DW-1:0] rdData,
  output logic [VW-1:0] dacCode,
  output logic [1:0]    outSel,
  output logic          rangeLift,
  output logic          pinSwClosed,
  output logic          bufSwClosed,
  output logic          supplySwClosed
);
  localparam logic [VW-1:0] MSB_FLIP = VW'(1) << (VW - 1);

  logic [DW-1:0] cfgReg;
  logic [VW-1:0] curVal;
  logic [VW-1:0] nextVal;
  logic          swPin;
  logic          swSupply;
  out_sel_e      sel;

  assign cfg = cfg_t'(cfgReg);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgReg   <= '0;
      curVal   <= '0;
      nextVal  <= '0;
      swPin    <= 1'b0;
      swSupply <= 1'b0;
    end else begin
      if (wrEn && wrAddr == A_CFG)  cfgReg  <= wrData;
      if (wrEn && wrAddr == A_NEXT) nextVal <= wrData[VW-1:0];
      if (seqStrobes.doUpdate)      curVal  <= nextVal;
      else if (seqStrobes.curWrite) curVal  <= wrData[VW-1:0];
      if (wrEn && wrAddr == A_SWSET) begin
        if (wrData[0]) swSupply <= 1'b1;
        if (wrData[1]) swPin    <= 1'b1;
      end
      if (wrEn && wrAddr == A_SWCLR) begin
        if (wrData[0]) swSupply <= 1'b0;
        if (wrData[1]) swPin    <= 1'b0;
      end
    end
  end

  always_comb begin
    unique case (cfg.codeMode)
      2'd1:    dacCode = curVal ^ MSB_FLIP;
      default: dacCode = curVal;
    endcase
  end

  always_comb begin
    if (!cfg.coreOn)     sel = OUT_HIZ;
    else if (cfg.outOn)  sel = OUT_DRIVE;
    else if (cfg.offDrive) sel = cfg.rangeUp ? OUT_REF : OUT_LOW;
    else                 sel = OUT_HIZ;
  end
  assign outSel    = sel;
  assign rangeLift = cfg.coreOn & cfg.rangeUp;

  assign pinSwClosed    = cfg.coreOn & swPin &
                          ~(cfg.glitchPinEn & seqStrobes.glitchOpen);
  assign bufSwClosed    = cfg.coreOn &
                          ~(cfg.glitchBufEn & seqStrobes.glitchOpen);
  assign supplySwClosed = cfg.coreOn & swSupply;

  always_comb begin
    rdData = '0;
    unique case (rdAddr)
      A_CFG:    rdData = cfgReg;
      A_CUR:    rdData = DW'(curVal);
      A_NEXT:   rdData = DW'(nextVal);
      A_IRQ:    rdData = DW'(irqFlag);
      A_MASK:   rdData = DW'(irqMask);
      A_MASKED: rdData = DW'(irqFlag & irqMask);
      A_SWSET, A_SWCLR: rdData = DW'({swPin, swSupply});
      default:  rdData = '0;
    endcase
  end
endmodule

// File: rtl/dac_update_seq.sv
module dac_update_seq
  import dac_seq_pkg::*;
#(
  parameter int VW = VAL_W,
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [AW-1:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic [AW-1:0] rdAddr,
  output logic [DW-1:0] rdData,
  input  logic          strobeIn,
  input  logic          dacTick,
  output logic [VW-1:0] dacCode,
  output logic [1:0]    outSel,
  output logic          rangeLift,
  output logic          pinSwClosed,
  output logic          bufSwClosed,
  output logic          supplySwClosed,
  output logic          irqOut
);
  cfg_t        cfg;
  seq_strobe_t seqStrobes;
  logic        irqFlag;
  logic        irqMask;

  dac_seq_ctrl #(.GW(GLITCH_W), .AW(AW)) ctrlU (
    .clk(clk), .rstN(rstN),
    .coreOn(cfg.coreOn), .strobeGate(cfg.strobeGate),
    .strobeLevel(cfg.strobeLevel), .glitchLen(cfg.glitchLen),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
    .strobeIn(strobeIn), .dacTick(dacTick),
    .seqStrobes(seqStrobes), .irqFlag(irqFlag), .irqMask(irqMask)
  );

  dac_seq_datapath #(.VW(VW), .AW(AW), .DW(DW)) dpU (
    .clk(clk), .rstN(rstN),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .rdAddr(rdAddr),
    .seqStrobes(seqStrobes), .irqFlag(irqFlag), .irqMask(irqMask),
    .cfg(cfg), .rdData(rdData), .dacCode(dacCode), .outSel(outSel),
    .rangeLift(rangeLift), .pinSwClosed(pinSwClosed),
    .bufSwClosed(bufSwClosed), .supplySwClosed(supplySwClosed)
  );

  assign irqOut = irqFlag & irqMask;
endmodule

// File: rtl/dac_update_seq_chk.sv
module dac_update_seq_chk
  import dac_seq_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input cfg_t              cfg,
  input seq_strobe_t       st,
  input logic              armed,
  input logic [VAL_W-1:0]  curVal,
  input logic [VAL_W-1:0]  nextVal,
  input logic              irqFlag,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic              wrBit0,
  input logic              strobeIn,
  input logic              dacTick,
  input logic              pinSwClosed,
  input logic              bufSwClosed,
  input logic              supplySwClosed
);
  p_update_copies_r1: assert property (@(posedge clk) disable iff (!rstN)
    st.doUpdate |=> (curVal == $past(nextVal)) && irqFlag);

  p_ungated_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.coreOn && !cfg.strobeGate && dacTick) |-> st.doUpdate);

  p_no_tick_no_update_r2: assert property (@(posedge clk) disable iff (!rstN)
    !dacTick |-> !st.doUpdate);

  p_edge_needs_arm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strobeGate && !cfg.strobeLevel && !armed) |-> !st.doUpdate);

  p_edge_disarm_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strobeGate && !cfg.strobeLevel && st.doUpdate) |=> !armed);

  p_level_low_r4: assert property (@(posedge clk) disable iff (!rstN)
    (cfg.strobeGate && cfg.strobeLevel && !strobeIn) |-> !st.doUpdate);

  p_window_opens_r6: assert property (@(posedge clk) disable iff (!rstN)
    (st.doUpdate || st.curWrite) |=> st.glitchOpen);

  p_pin_forced_open_r7: assert property (@(posedge clk) disable iff (!rstN)
    (st.glitchOpen && cfg.glitchPinEn) |-> !pinSwClosed);

  p_irq_set_r8: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrAddr == A_IRQSET && wrBit0) |=> irqFlag);

  p_core_off_r9: assert property (@(posedge clk) disable iff (!rstN)
    !cfg.coreOn |-> (!pinSwClosed && !bufSwClosed && !supplySwClosed && !st.doUpdate));

  p_hw_wins_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    (st.doUpdate && wrEn && wrAddr == A_IRQ && wrBit0) |=> irqFlag);
endmodule

bind dac_update_seq dac_update_seq_chk chkU (
  .clk(clk), .rstN(rstN), .cfg(cfg), .st(seqStrobes),
  .armed(ctrlU.armed), .curVal(dpU.curVal), .nextVal(dpU.nextVal),
  .irqFlag(irqFlag), .wrEn(wrEn), .wrAddr(wrAddr), .wrBit0(wrData[0]),
  .strobeIn(strobeIn), .dacTick(dacTick), .pinSwClosed(pinSwClosed),
  .bufSwClosed(bufSwClosed), .supplySwClosed(supplySwClosed)
);

// File: tb/dac_update_seq_test.sv
module dac_update_seq_test;
  logic        clk = 0;
  logic        rstN = 0;
  logic        wrEn = 0;
  logic [3:0]  wrAddr = 0;
  logic [15:0] wrData = 0;
  logic [3:0]  rdAddr = 0;
  logic [15:0] rdData;
  logic        strobeIn = 0;
  logic        dacTick = 0;
  logic [11:0] dacCode;
  logic [1:0]  outSel;
  logic        rangeLift, pinSwClosed, bufSwClosed, supplySwClosed, irqOut;

  int total = 0;
  int bad = 0;
  bit done = 0;

  dac_update_seq uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .rdAddr(rdAddr), .rdData(rdData), .strobeIn(strobeIn), .dacTick(dacTick),
    .dacCode(dacCode), .outSel(outSel), .rangeLift(rangeLift),
    .pinSwClosed(pinSwClosed), .bufSwClosed(bufSwClosed),
    .supplySwClosed(supplySwClosed), .irqOut(irqOut)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] mkCfg(bit core, bit gate, bit lvl,
      bit [1:0] mode, bit off, bit rng, bit outOn, bit bufEn, bit pinEn,
      bit [5:0] len);
    return {core, lvl, gate, off, mode, rng, outOn, bufEn, pinEn, len};
  endfunction

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk); wrEn = 1; wrAddr = a; wrData = d;
    @(negedge clk); wrEn = 0;
  endtask

  task automatic rd(input logic [3:0] a, output int d);
    rdAddr = a; #1; d = int'(rdData);
  endtask

  task automatic drive(input logic s, input logic t);
    @(negedge clk); strobeIn = s; dacTick = t;
    @(negedge clk); dacTick = 0;
  endtask

  task automatic measure(output int pinOpen, output int bufOpen);
    pinOpen = 0; bufOpen = 0;
    for (int k = 0; k < 80; k++) begin
      if (!pinSwClosed) pinOpen++;
      if (!bufSwClosed) bufOpen++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int v, p, b;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // reset state
    rd(4'h0, v); check("R9 reset cfg", v, 0);
    rd(4'h1, v); check("R1 reset cur", v, 0);
    rd(4'h3, v); check("R8 reset irq", v, 0);
    check("R9 reset outSel", outSel, 0);
    check("R9 reset switches", {pinSwClosed, bufSwClosed, supplySwClosed}, 0);

    // R5 decode sweep
    for (int m = 0; m < 4; m++) begin
      wr(4'h0, mkCfg(1, 0, 0, 2'(m), 0, 0, 1, 0, 0, 0));
      for (int x = 0; x < 4096; x++) begin
        wr(4'h1, 16'(x));
        check($sformatf("R5 mode%0d val%0h", m, x), dacCode,
              (m == 1) ? (x ^ 'h800) : x);
      end
    end

    // R1 / R2 ungated updates
    wr(4'h0, mkCfg(1, 0, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(4'h3, 1);
    for (int i = 0; i < 8; i++) begin
      v = 'h111 * (i + 1) + i;
      wr(4'h2, 16'(v));
      drive(1'(i % 2), 0);
      rd(4'h1, p); check("R2 no tick no update", p, (i == 0) ? 'hfff : ('h111 * i + i - 1));
      drive(1'((i + 1) % 2), 1);
      rd(4'h1, p); check("R1 R2 cur copied", p, v);
      rd(4'h2, p); check("R1 next kept", p, v);
      rd(4'h3, p); check("R1 irq set", p, 1);
      wr(4'h3, 1);
    end

    // R8 interrupt set/clear/mask
    rd(4'h3, v); check("R8 cleared", v, 0);
    wr(4'h4, 0); rd(4'h3, v); check("R8 set write 0", v, 0);
    wr(4'h4, 1); rd(4'h3, v); check("R8 set", v, 1);
    check("R8 masked off", irqOut, 0);
    wr(4'h5, 1); check("R8 masked on", irqOut, 1);
    rd(4'h6, v); check("R8 masked reg", v, 1);
    wr(4'h3, 0); rd(4'h3, v); check("R8 clear write 0", v, 1);
    wr(4'h3, 1); rd(4'h3, v); check("R8 clear", v, 0);
    check("R8 irqOut low", irqOut, 0);

    // R11 hardware set beats clear
    wr(4'h2, 'h5a5);
    @(negedge clk); wrEn = 1; wrAddr = 4'h3; wrData = 1; dacTick = 1;
    @(negedge clk); wrEn = 0; dacTick = 0;
    rd(4'h3, v); check("R11 irq after collide", v, 1);
    rd(4'h1, v); check("R11 update done", v, 'h5a5);

    // R4 level mode
    wr(4'h0, mkCfg(1, 1, 1, 0, 0, 0, 1, 0, 0, 0));
    wr(4'h1, 'h321);
    wr(4'h2, 'h400);
    drive(0, 1); rd(4'h1, v); check("R4 strobe low blocks", v, 'h321);
    drive(1, 1); rd(4'h1, v); check("R4 strobe high updates", v, 'h400);
    wr(4'h2, 'h401);
    drive(1, 1); rd(4'h1, v); check("R4 held high updates again", v, 'h401);

    // R3 edge mode
    drive(0, 0);
    wr(4'h0, mkCfg(1, 1, 0, 0, 0, 0, 1, 0, 0, 0));
    wr(4'h1, 'h321);
    wr(4'h2, 'h055);
    drive(0, 1); rd(4'h1, v); check("R3 no edge no update", v, 'h321);
    drive(1, 1); rd(4'h1, v); check("R3 same-edge tick skipped", v, 'h321);
    drive(1, 1); rd(4'h1, v); check("R3 armed update", v, 'h055);
    wr(4'h2, 'h0aa);
    drive(1, 1); rd(4'h1, v); check("R3 held high no rearm", v, 'h055);
    drive(0, 0); drive(1, 0); drive(0, 0); drive(1, 0);
    drive(1, 1); rd(4'h1, v); check("R3 one update for two edges", v, 'h0aa);
    wr(4'h2, 'h0bb);
    drive(1, 1); rd(4'h1, v); check("R3 extra edge ignored", v, 'h0aa);
    drive(0, 0);

    // R6 / R7 deglitch window sweep
    wr(4'h7, 'h3);
    for (int len = 0; len < 64; len++) begin
      wr(4'h0, mkCfg(1, 0, 0, 0, 0, 0, 1, 1, 1, 6'(len)));
      repeat (70) @(negedge clk);
      check("R7 idle pin closed", pinSwClosed, 1);
      check("R7 idle buf closed", bufSwClosed, 1);
      wr(4'h1, 16'(len));
      measure(p, b);
      check($sformatf("R6 pin window len%0d", len), p, len + 1);
      check($sformatf("R6 buf window len%0d", len), b, len + 1);
    end
    wr(4'h0, mkCfg(1, 0, 0, 0, 0, 0, 1, 1, 0, 5));
    wr(4'h1, 'h10);
    measure(p, b);
    check("R7 pin enable off", p, 0);
    check("R7 buf enable on", b, 6);
    wr(4'h0, mkCfg(1, 0, 0, 0, 0, 0, 1, 0, 1, 9));
    drive(0, 1);
    measure(p, b);
    check("R6 window after update", p, 10);
    check("R7 buf enable off", b, 0);
    check("R7 supply follows bit", supplySwClosed, 1);
    wr(4'h8, 'h2);
    check("R7 pin cleared", pinSwClosed, 0);
    rd(4'h7, v); check("R7 switch state", v, 1);

    // R10 output select / R9 core off
    for (int c = 0; c < 8; c++) begin
      bit o, f, r;
      o = c[0]; f = c[1]; r = c[2];
      wr(4'h0, mkCfg(1, 0, 0, 0, f, r, o, 0, 0, 0));
      check("R10 outSel", outSel, o ? 1 : (f ? (r ? 3 : 2) : 0));
      check("R10 rangeLift", rangeLift, r);
    end
    wr(4'h7, 'h3);
    wr(4'h0, mkCfg(0, 0, 0, 0, 1, 1, 1, 0, 0, 0));
    check("R9 outSel hiz", outSel, 0);
    check("R9 switches open", {pinSwClosed, bufSwClosed, supplySwClosed}, 0);
    rd(4'h1, p);
    wr(4'h2, 'h777);
    drive(0, 1);
    rd(4'h1, v); check("R9 no update when off", v, p);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule